// File: doc/BRIEF.md
# Eight-Stage Pipeline Hazard Interlock

This block is the stall and kill controller for an in-order pipeline with eight stages: fetch start, fetch finish, decode/register read, execute, two data-cache stages, tag check and writeback. Hazards are checked in the decode stage. Each cycle the block looks at the instruction in decode (its source registers and which of them it reads) and at the three older instructions in execute, first data stage and second data stage (valid bit, whether each is a load, destination register). It also looks at the branch outcome resolved in execute. From these it decides whether the front end must hold, whether a bubble enters execute, whether the two wrong-path instructions in the fetch stages are killed, and whether the delay-slot instruction in decode is cancelled.

Load data is usable two cycles after the load leaves execute. A consumer right behind a load therefore holds for two cycles, and a consumer two slots behind holds for one. A branch costs three cycles. The delay slot always runs for an ordinary branch. On a taken branch, the two younger fetched instructions are discarded. A likely-form branch that is not taken cancels its own delay slot. The block is purely combinational. Its outputs drive the valid bits and enables of the pipeline registers around it, and it contains no datapath or forwarding.

Top module: `pipe_interlock`

## Requirements
- R1: When the execute-stage instruction (bit 0 of the older-stage vectors, destination in old_dst[REG_W-1:0]) is a valid load whose destination equals a source that the valid decode instruction reads, hold_front is 1.
- R2: When the first data-stage instruction (bit 1, destination in old_dst[2*REG_W-1:REG_W]) is a valid load matching a read source, hold_front is 1. This gives the second stall cycle for a consumer right behind a load, and the single stall for a consumer two slots behind.
- R3: A matching valid load in the second data stage (bit 2) causes no hold, because its data can be forwarded.
- R4: No hold arises from a non-load older instruction, an invalid older stage, an invalid decode instruction, a source whose read flag is 0, or a source that differs from the destination. With all inputs idle, every output is 0.
- R5: Register 0 never creates a hazard, even when a load names it as its destination.
- R6: A valid branch in execute with taken=1 asserts squash_wrong, which kills the instructions in both fetch stages. A branch flag in an invalid execute stage has no effect.
- R7: A valid ordinary branch that is not taken asserts no squash output.
- R8: A valid likely-form branch that is not taken asserts squash_slot, which cancels the decode instruction. A taken likely-form branch asserts squash_wrong and not squash_slot. The two squash outputs are never 1 together.
- R9: squash_wrong asserts in the same cycle as a load-use hold of the delay slot, so the frozen wrong-path fetch instructions are still killed.
- R10: A delay slot that is being cancelled never causes a hold, even if it matches a pending load.
- R11: inject_bubble equals hold_front in every cycle.
- R12: The second source operand is checked the same way as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_valid | input | 1 | Decode-stage instruction is valid |
| rf_use_a | input | 1 | Decode instruction reads source A |
| rf_src_a | input | REG_W | Source A register number |
| rf_use_b | input | 1 | Decode instruction reads source B |
| rf_src_b | input | REG_W | Source B register number |
| old_valid | input | NUM_OLDER | Valid bits of older stages, bit 0 execute, bit 1 first data stage, bit 2 second data stage |
| old_load | input | NUM_OLDER | Older stage holds a load, same bit order |
| old_dst | input | NUM_OLDER*REG_W | Destination registers of older stages, stage s at [s*REG_W +: REG_W] |
| ex_branch | input | 1 | Execute-stage instruction is a branch |
| ex_likely | input | 1 | That branch is the likely form |
| ex_taken | input | 1 | Branch outcome resolved in execute |
| hold_front | output | 1 | Freeze both fetch stages and decode |
| inject_bubble | output | 1 | Put an invalid slot into execute |
| squash_wrong | output | 1 | Clear valid of both fetch-stage instructions |
| squash_slot | output | 1 | Clear valid of the decode instruction (delay slot) |

## Verification
The checker assumes that an execute-stage instruction is never both a branch and a load, and that the likely flag has meaning only together with the branch flag. Every stimulus vector and directed case follows this rule: loads and branches never share bit 0 of the older-stage inputs. The checker's hold-cause assertion also assumes that old_dst bits are meaningful only where the matching valid and load bits are set. The bench varies destinations freely in the other stages to show that those values are ignored.

// File: rtl/pipe_interlock_pkg.sv
package pipe_interlock_pkg;

   // Older-stage positions in the per-stage input vectors.
   localparam int STG_EXEC  = 0;
   localparam int STG_DATA1 = 1;
   localparam int STG_DATA2 = 2;

   // Control decisions produced each cycle.
   typedef struct packed {
      logic hold;
      logic bubble;
      logic wrong;
      logic slot;
   } ilk_ctl_t;

endpackage

// File: rtl/ilk_load_use.sv
module ilk_load_use #(
   parameter int REG_W      = 5,
   parameter int NUM_OLDER  = 3,
   parameter int LOAD_LAT   = 2,
   parameter bit ZERO_CONST = 1'b1
) (
   input  logic                       rf_valid,
   input  logic                       rf_use_a,
   input  logic [REG_W-1:0]           rf_src_a,
   input  logic                       rf_use_b,
   input  logic [REG_W-1:0]           rf_src_b,
   input  logic [NUM_OLDER-1:0]       old_valid,
   input  logic [NUM_OLDER-1:0]       old_load,
   input  logic [NUM_OLDER*REG_W-1:0] old_dst,
   output logic                       raw_hit
);

   // Stages whose load result is not yet available to decode.
   localparam logic [NUM_OLDER-1:0] LAT_MASK = NUM_OLDER'((1 << LOAD_LAT) - 1);

   logic                 live_a;
   logic                 live_b;
   logic [NUM_OLDER-1:0] stg_hit;

   generate
      if (ZERO_CONST) begin : g_zero_const
         assign live_a = rf_use_a & (|rf_src_a);
         assign live_b = rf_use_b & (|rf_src_b);
      end else begin : g_zero_plain
         assign live_a = rf_use_a;
         assign live_b = rf_use_b;
      end
   endgenerate

   generate
      for (genvar s = 0; s < NUM_OLDER; s++) begin : g_stage
         logic [REG_W-1:0] dst;
         logic             match_a;
         logic             match_b;
         assign dst        = old_dst[s*REG_W +: REG_W];
         assign match_a    = live_a & (rf_src_a == dst);
         assign match_b    = live_b & (rf_src_b == dst);
         assign stg_hit[s] = old_valid[s] & old_load[s] & (match_a | match_b);
      end
   endgenerate

   assign raw_hit = rf_valid & (|(stg_hit & LAT_MASK));

endmodule

// File: rtl/ilk_branch_ctl.sv
module ilk_branch_ctl (
   input  logic ex_valid,
   input  logic ex_branch,
   input  logic ex_likely,
   input  logic ex_taken,
   output logic kill_fetch,
   output logic kill_slot
);

   logic live;

   assign live       = ex_valid & ex_branch;
   assign kill_fetch = live & ex_taken;
   assign kill_slot  = live & ex_likely & ~ex_taken;

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
   import pipe_interlock_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter int NUM_OLDER  = 3,
   parameter int LOAD_LAT   = 2,
   parameter bit ZERO_CONST = 1'b1
) (
   input  logic                       rf_valid,
   input  logic                       rf_use_a,
   input  logic [REG_W-1:0]           rf_src_a,
   input  logic                       rf_use_b,
   input  logic [REG_W-1:0]           rf_src_b,
   input  logic [NUM_OLDER-1:0]       old_valid,
   input  logic [NUM_OLDER-1:0]       old_load,
   input  logic [NUM_OLDER*REG_W-1:0] old_dst,
   input  logic                       ex_branch,
   input  logic                       ex_likely,
   input  logic                       ex_taken,
   output logic                       hold_front,
   output logic                       inject_bubble,
   output logic                       squash_wrong,
   output logic                       squash_slot
);

   generate
      if (REG_W < 1) begin : g_bad_regw
         $error("pipe_interlock: REG_W must be at least 1");
      end
      if (NUM_OLDER < 1 || NUM_OLDER > 16) begin : g_bad_older
         $error("pipe_interlock: NUM_OLDER out of range");
      end
      if (LOAD_LAT < 1 || LOAD_LAT > NUM_OLDER) begin : g_bad_lat
         $error("pipe_interlock: LOAD_LAT must lie within the tracked stages");
      end
   endgenerate

   logic     raw_hit;
   logic     kill_fetch;
   logic     kill_slot;
   ilk_ctl_t ctl;

   ilk_load_use #(
      .REG_W(REG_W), .NUM_OLDER(NUM_OLDER),
      .LOAD_LAT(LOAD_LAT), .ZERO_CONST(ZERO_CONST)
   ) u_lu (
      .rf_valid (rf_valid),
      .rf_use_a (rf_use_a),
      .rf_src_a (rf_src_a),
      .rf_use_b (rf_use_b),
      .rf_src_b (rf_src_b),
      .old_valid(old_valid),
      .old_load (old_load),
      .old_dst  (old_dst),
      .raw_hit  (raw_hit)
   );

   ilk_branch_ctl u_br (
      .ex_valid  (old_valid[STG_EXEC]),
      .ex_branch (ex_branch),
      .ex_likely (ex_likely),
      .ex_taken  (ex_taken),
      .kill_fetch(kill_fetch),
      .kill_slot (kill_slot)
   );

   // A cancelled delay slot cannot stall; the fetch kill is never gated by a hold.
   always_comb begin
      ctl.slot   = kill_slot;
      ctl.wrong  = kill_fetch;
      ctl.hold   = raw_hit & ~kill_slot;
      ctl.bubble = ctl.hold;
   end

   assign hold_front    = ctl.hold;
   assign inject_bubble = ctl.bubble;
   assign squash_wrong  = ctl.wrong;
   assign squash_slot   = ctl.slot;

endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
   parameter int REG_W      = 5,
   parameter int NUM_OLDER  = 3,
   parameter int LOAD_LAT   = 2,
   parameter bit ZERO_CONST = 1'b1
) (
   input logic                 rf_valid,
   input logic                 rf_use_a,
   input logic [REG_W-1:0]     rf_src_a,
   input logic                 rf_use_b,
   input logic [REG_W-1:0]     rf_src_b,
   input logic [NUM_OLDER-1:0] old_valid,
   input logic [NUM_OLDER-1:0] old_load,
   input logic                 ex_branch,
   input logic                 ex_likely,
   input logic                 ex_taken,
   input logic                 hold_front,
   input logic                 inject_bubble,
   input logic                 squash_wrong,
   input logic                 squash_slot
);

   localparam logic [NUM_OLDER-1:0] LAT_MASK = NUM_OLDER'((1 << LOAD_LAT) - 1);

   logic a_nz;
   logic b_nz;

   generate
      if (ZERO_CONST) begin : g_zc
         assign a_nz = rf_use_a && (rf_src_a != '0);
         assign b_nz = rf_use_b && (rf_src_b != '0);
      end else begin : g_nzc
         assign a_nz = rf_use_a;
         assign b_nz = rf_use_b;
      end
   endgenerate

   always_comb begin
      // R8
      slot_wrong_excl_chk: assert (!(squash_slot && squash_wrong));
      // R8
      slot_cause_chk: assert (!squash_slot || (old_valid[0] && ex_branch && ex_likely && !ex_taken));
      // R6
      wrong_cause_chk: assert (!squash_wrong || (old_valid[0] && ex_branch && ex_taken));
      // R10
      slot_no_hold_chk: assert (!(squash_slot && hold_front));
      // R4
      hold_cause_chk: assert (!hold_front || (rf_valid && (|(old_valid & old_load & LAT_MASK))));
      // R5
      hold_src_chk: assert (!hold_front || a_nz || b_nz);
      // R11
      bubble_match_chk: assert (inject_bubble == hold_front);
   end

endmodule

bind pipe_interlock pipe_interlock_chk #(
   .REG_W(REG_W), .NUM_OLDER(NUM_OLDER),
   .LOAD_LAT(LOAD_LAT), .ZERO_CONST(ZERO_CONST)
) u_chk (
   .rf_valid     (rf_valid),
   .rf_use_a     (rf_use_a),
   .rf_src_a     (rf_src_a),
   .rf_use_b     (rf_use_b),
   .rf_src_b     (rf_src_b),
   .old_valid    (old_valid),
   .old_load     (old_load),
   .ex_branch    (ex_branch),
   .ex_likely    (ex_likely),
   .ex_taken     (ex_taken),
   .hold_front   (hold_front),
   .inject_bubble(inject_bubble),
   .squash_wrong (squash_wrong),
   .squash_slot  (squash_slot)
);

// File: tb/sim_pipe_interlock.sv
module sim_pipe_interlock;

   localparam int CLK_PERIOD = 10;
   localparam int RW = 5;
   localparam int NO = 3;

   typedef struct packed {
      logic          rv;
      logic          ua;
      logic [RW-1:0] sa;
      logic          ub;
      logic [RW-1:0] sb;
      logic [NO-1:0] ov;
      logic [NO-1:0] ol;
      logic [NO*RW-1:0] od;
      logic          br;
      logic          lk;
      logic          tk;
      logic          eh;
      logic          ew;
      logic          es;
      logic [3:0]    rq;
   } vec_t;

   localparam int NV = 16;
   // Each vector: decode fields, older-stage fields {DS,DF,EX}, branch fields, expected hold/wrong/slot, requirement.
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b1,5'd3,1'b0,5'd0, 3'b001,3'b001,{5'd0,5'd0,5'd3}, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd1},  // R1
      '{1'b1,1'b0,5'd0,1'b1,5'd7, 3'b001,3'b001,{5'd0,5'd0,5'd7}, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd12}, // R12
      '{1'b1,1'b1,5'd4,1'b0,5'd0, 3'b010,3'b010,{5'd0,5'd4,5'd0}, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd2},  // R2
      '{1'b1,1'b1,5'd4,1'b0,5'd0, 3'b100,3'b100,{5'd4,5'd0,5'd0}, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd3},  // R3
      '{1'b1,1'b1,5'd3,1'b0,5'd0, 3'b001,3'b000,{5'd0,5'd0,5'd3}, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd4},  // R4 non-load
      '{1'b0,1'b1,5'd3,1'b0,5'd0, 3'b001,3'b001,{5'd0,5'd0,5'd3}, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd4},  // R4 decode invalid
      '{1'b1,1'b0,5'd3,1'b0,5'd3, 3'b001,3'b001,{5'd0,5'd0,5'd3}, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd4},  // R4 flags clear
      '{1'b1,1'b1,5'd3,1'b1,5'd6, 3'b011,3'b001,{5'd3,5'd3,5'd5}, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd4},  // R4 mismatch
      '{1'b1,1'b1,5'd0,1'b1,5'd0, 3'b011,3'b011,{5'd0,5'd0,5'd0}, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd5},  // R5
      '{1'b1,1'b1,5'd2,1'b0,5'd0, 3'b001,3'b000,{5'd0,5'd0,5'd2}, 1'b1,1'b0,1'b1, 1'b0,1'b1,1'b0, 4'd6},  // R6
      '{1'b1,1'b1,5'd2,1'b0,5'd0, 3'b000,3'b000,{5'd0,5'd0,5'd2}, 1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0, 4'd6},  // R6 invalid stage
      '{1'b1,1'b1,5'd2,1'b0,5'd0, 3'b001,3'b000,{5'd0,5'd0,5'd2}, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd7},  // R7
      '{1'b1,1'b1,5'd2,1'b0,5'd0, 3'b001,3'b000,{5'd0,5'd0,5'd0}, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1, 4'd8},  // R8 not taken
      '{1'b1,1'b1,5'd2,1'b0,5'd0, 3'b001,3'b000,{5'd0,5'd0,5'd0}, 1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0, 4'd8},  // R8 taken
      '{1'b1,1'b1,5'd9,1'b0,5'd0, 3'b011,3'b010,{5'd0,5'd9,5'd0}, 1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0, 4'd9},  // R9
      '{1'b1,1'b1,5'd9,1'b0,5'd0, 3'b011,3'b010,{5'd0,5'd9,5'd0}, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1, 4'd10}  // R10
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          rf_valid, rf_use_a, rf_use_b;
   logic [RW-1:0] rf_src_a, rf_src_b;
   logic [NO-1:0] old_valid, old_load;
   logic [NO*RW-1:0] old_dst;
   logic ex_branch, ex_likely, ex_taken;
   logic hold_front, inject_bubble, squash_wrong, squash_slot;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe_interlock u0 (
      .rf_valid(rf_valid), .rf_use_a(rf_use_a), .rf_src_a(rf_src_a),
      .rf_use_b(rf_use_b), .rf_src_b(rf_src_b),
      .old_valid(old_valid), .old_load(old_load), .old_dst(old_dst),
      .ex_branch(ex_branch), .ex_likely(ex_likely), .ex_taken(ex_taken),
      .hold_front(hold_front), .inject_bubble(inject_bubble),
      .squash_wrong(squash_wrong), .squash_slot(squash_slot)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      rf_valid = v.rv; rf_use_a = v.ua; rf_src_a = v.sa;
      rf_use_b = v.ub; rf_src_b = v.sb;
      old_valid = v.ov; old_load = v.ol; old_dst = v.od;
      ex_branch = v.br; ex_likely = v.lk; ex_taken = v.tk;
   endtask

   task automatic idle();
      apply('0);
   endtask

   task automatic check_all(input string req, input logic eh, input logic ew, input logic es);
      chk(req, "hold_front", hold_front, eh);
      chk(req, "squash_wrong", squash_wrong, ew);
      chk(req, "squash_slot", squash_slot, es);
      chk({req, "/R11"}, "inject_bubble", inject_bubble, eh);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      // R4: idle inputs during reset give all-zero outputs
      @(negedge clk);
      check_all("R4 reset", 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(VECS[i]);
         #1;
         check_all($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].eh, VECS[i].ew, VECS[i].es);
      end

      // R1 R2 R3: consumer right behind a load, load advancing EX -> DF -> DS
      for (int step = 0; step < 3; step++) begin
         @(negedge clk);
         idle();
         rf_valid = 1'b1; rf_use_b = 1'b1; rf_src_b = 5'd17;
         old_valid[step] = 1'b1; old_load[step] = 1'b1;
         old_dst[step*RW +: RW] = 5'd17;
         #1;
         chk(step == 0 ? "R1 seq" : (step == 1 ? "R2 seq" : "R3 seq"),
             "hold_front", hold_front, step < 2);
      end

      // R5: load to register 0 in execute, decode reads register 0 on both sources
      @(negedge clk);
      idle();
      rf_valid = 1'b1; rf_use_a = 1'b1; rf_use_b = 1'b1;
      old_valid = 3'b001; old_load = 3'b001;
      #1;
      chk("R5 zero", "hold_front", hold_front, 1'b0);

      // R12: source B matches a load in the first data stage while source A does not
      @(negedge clk);
      idle();
      rf_valid = 1'b1; rf_use_a = 1'b1; rf_src_a = 5'd1; rf_use_b = 1'b1; rf_src_b = 5'd31;
      old_valid = 3'b010; old_load = 3'b010; old_dst = {5'd0, 5'd31, 5'd0};
      #1;
      chk("R12 src b", "hold_front", hold_front, 1'b1);

      @(negedge clk);
      idle();
      #1;
      chk("R4 idle", "hold_front", hold_front, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule